// File: doc/BRIEF.md
# I2C Bus Clock Period and Data-Hold Timer

This block produces the serial clock waveform of an I2C controller acting as bus master, and marks the moment in each bit at which the data line may take its next value. It counts system clock cycles. Three byte-wide configuration registers set the timing: the length of the clock low phase, the length of the clock high phase, and the delay from each clock falling edge to the data-change point. When the clock train is enabled, the block alternates low and high phases. When the enable is removed, the clock is released high after the phase pair in progress ends.

In slave mode the block does not drive the clock. It watches the incoming bus clock through a synchronizer and times the data-change point from each falling edge it detects. In this mode the delay is four cycles longer than the register value. If a falling edge arrives while a data-change point is still pending, the pending point is discarded, a one-cycle overrun pulse is raised, and timing restarts from the new edge. The data-change strobe is meant to advance a separate data shifter.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the register at address 0 (low period) and the one at address 1 (high period) read 0x3F, and the one at address 2 (hold delay) reads 0x01. After reset `scl_out` is 1 and `sda_strobe` and `hold_overrun` are 0.
- R2: In master mode with `run` set, every low phase of `scl_out` lasts exactly 4*L+1 system clock cycles, where L is the address-0 register value.
- R3: In master mode with `run` set, every high phase of `scl_out` between two low phases lasts exactly 4*H+3 cycles, where H is the address-1 register value.
- R4: In master mode, with the first low cycle of `scl_out` taken as cycle 0, `sda_strobe` is high for one cycle in cycle D, where D is the address-2 register value. D = 0 puts the strobe in the same cycle as the falling edge.
- R5: In slave mode, with the first cycle in which `scl_in` is presented low after being high taken as cycle 0, `sda_strobe` is high in cycle D+4.
- R6: If a falling edge (driven in master mode, detected in slave mode) arrives while a strobe is pending and not firing in that cycle, `hold_overrun` is high for exactly that one cycle, the pending strobe never fires, and the delay restarts from the new edge.
- R7: A register write takes effect only at the start of the next phase that uses the register. A low or high phase already running keeps the length it started with.
- R8: When `run` falls, the current low phase (if any) and the following high phase complete, after which `scl_out` stays 1 and no further low phase starts.
- R9: Writes to address 3 change nothing and reading address 3 returns 0. Addresses 0 to 2 read back the last value written.
- R10: While `slave_mode` is 1, `scl_out` stays 1 whatever the value of `run`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low period, 1 high period, 2 hold delay |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| run | input | 1 | Enables the master clock train |
| slave_mode | input | 1 | 1: time strobes from incoming clock; 0: master |
| scl_in | input | 1 | Incoming bus clock, used in slave mode |
| scl_out | output | 1 | Generated bus clock (1 means released) |
| sda_strobe | output | 1 | One-cycle data-change point |
| hold_overrun | output | 1 | One-cycle pulse when a pending strobe is dropped |

## Verification
The hardest situation to reach from the ports is the overrun. It needs a falling edge to arrive while a strobe is still counting. The bench provokes it in two ways. In master mode it uses the shortest clock period (both period registers zero) with a hold delay longer than that period. In slave mode it toggles `scl_in` faster than the hold delay plus four. It then checks that only the strobe of the final edge survives, at the delay measured from that edge. Mid-phase register writes are timed from an observed falling edge, so the bench knows which phase is running when each write lands.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned NUM_REGS   = 3;
  localparam logic [ADDR_W-1:0] ADR_LOW  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_HOLD = 2'd2;

  // Phase length = (reg << MULT_SHIFT) + offset
  localparam int unsigned MULT_SHIFT = 2;
  localparam int unsigned LOW_OFS    = 1;
  localparam int unsigned HIGH_OFS   = 3;
  // Extra hold cycles in slave mode, counted from the raw input edge
  localparam int unsigned SLV_EXTRA  = 4;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_timing_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] RST_LOW  = 8'h3F,
  parameter logic [DATA_W-1:0] RST_HIGH = 8'h3F,
  parameter logic [DATA_W-1:0] RST_HOLD = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg_low,
  output logic [DATA_W-1:0] cfg_high,
  output logic [DATA_W-1:0] cfg_hold
);

  localparam logic [NUM_REGS-1:0][DATA_W-1:0] RST_VALS = {RST_HOLD, RST_HIGH, RST_LOW};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic              wen;
    logic [DATA_W-1:0] q;

    assign wen = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VALS[i];
      end else if (wen) begin
        q <= wr_data;
      end
    end
  end

  assign cfg_low  = g_reg[0].q;
  assign cfg_high = g_reg[1].q;
  assign cfg_hold = g_reg[2].q;

  always_comb begin
    case (rd_addr)
      ADR_LOW:  rd_data = cfg_low;
      ADR_HIGH: rd_data = cfg_high;
      ADR_HOLD: rd_data = cfg_hold;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = DATA_W + MULT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              abort,
  input  logic [DATA_W-1:0] cfg_low,
  input  logic [DATA_W-1:0] cfg_high,
  output phase_e            phase_q,
  output phase_e            phase_d,
  output logic              scl_out,
  output logic              fall
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] low_load, high_load;
  logic             scl_q, fall_q;
  logic             cnt_zero;

  // Counter is loaded with (length - 1) and expires at zero
  assign low_load  = (CNT_W'(cfg_low)  << MULT_SHIFT) + CNT_W'(LOW_OFS - 1);
  assign high_load = (CNT_W'(cfg_high) << MULT_SHIFT) + CNT_W'(HIGH_OFS - 1);
  assign cnt_zero  = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (run) begin
          phase_d = PH_LOW;
          cnt_d   = low_load;
        end
      end
      PH_LOW: begin
        if (cnt_zero) begin
          phase_d = PH_HIGH;
          cnt_d   = high_load;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (run) begin
          phase_d = PH_LOW;
          cnt_d   = low_load;
        end else begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (abort) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      scl_q   <= 1'b1;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      scl_q   <= (phase_d != PH_LOW);
      fall_q  <= (phase_d == PH_LOW) && (phase_q != PH_LOW);
    end
  end

  assign scl_out = scl_q;
  assign fall    = fall_q;

endmodule

// File: rtl/scl_edge_sync.sv
module scl_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_in,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;

  if (SYNC_STAGES == 1) begin : g_one
    assign sync_d = scl_in;
  end else begin : g_chain
    assign sync_d = {sync_q[SYNC_STAGES-2:0], scl_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = enable && prev_q && !sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer #(
  parameter int unsigned DLY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic [DLY_W-1:0] delay,
  output logic             strobe,
  output logic             overrun,
  output logic             pending
);

  logic             pend_q, pend_d;
  logic [DLY_W-1:0] hcnt_q, hcnt_d;
  logic             fire_now, fire_pend;

  assign fire_now  = fall && (delay == '0);
  assign fire_pend = pend_q && (hcnt_q == '0);
  assign strobe    = fire_now || fire_pend;
  assign overrun   = fall && pend_q && (hcnt_q != '0);
  assign pending   = pend_q;

  always_comb begin
    pend_d = pend_q;
    hcnt_d = hcnt_q;
    if (fall) begin
      pend_d = (delay != '0);
      hcnt_d = (delay != '0) ? (delay - 1'b1) : '0;
    end else if (pend_q) begin
      if (hcnt_q == '0) begin
        pend_d = 1'b0;
      end else begin
        hcnt_d = hcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      hcnt_q <= hcnt_d;
    end
  end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import scl_timing_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RST_LOW     = 8'h3F,
  parameter logic [DATA_W-1:0] RST_HIGH    = 8'h3F,
  parameter logic [DATA_W-1:0] RST_HOLD    = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              run,
  input  logic              slave_mode,
  input  logic              scl_in,
  output logic              scl_out,
  output logic              sda_strobe,
  output logic              hold_overrun
);

  // SYNC_STAGES must not exceed SLV_EXTRA: the synchronizer latency is
  // taken out of the slave-mode extra delay.
  localparam int unsigned DLY_W    = DATA_W + 1;
  localparam int unsigned SLV_TRIM = SLV_EXTRA - SYNC_STAGES;

  logic [1:0]        rst_pipe;
  logic              rst_ni;
  logic [DATA_W-1:0] cfg_low, cfg_high, cfg_hold;
  phase_e            phase_q, phase_d;
  logic              mst_fall, slv_fall, fall_sel;
  logic [DLY_W-1:0]  hold_dly;
  logic              hold_pend;
  logic              run_eff;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  scl_cfg_regs #(
    .DATA_W  (DATA_W),
    .RST_LOW (RST_LOW),
    .RST_HIGH(RST_HIGH),
    .RST_HOLD(RST_HOLD)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_low (cfg_low),
    .cfg_high(cfg_high),
    .cfg_hold(cfg_hold)
  );

  assign run_eff = run && !slave_mode;

  scl_phase_gen #(
    .DATA_W(DATA_W)
  ) i_phase (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (run_eff),
    .abort   (slave_mode),
    .cfg_low (cfg_low),
    .cfg_high(cfg_high),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .scl_out (scl_out),
    .fall    (mst_fall)
  );

  scl_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .enable(slave_mode),
    .scl_in(scl_in),
    .fall  (slv_fall)
  );

  assign fall_sel = slave_mode ? slv_fall : mst_fall;
  assign hold_dly = slave_mode ? (DLY_W'(cfg_hold) + DLY_W'(SLV_TRIM))
                               : DLY_W'(cfg_hold);

  sda_hold_timer #(
    .DLY_W(DLY_W)
  ) i_hold (
    .clk    (clk),
    .rst_n  (rst_ni),
    .fall   (fall_sel),
    .delay  (hold_dly),
    .strobe (sda_strobe),
    .overrun(hold_overrun),
    .pending(hold_pend)
  );

endmodule

// File: rtl/scl_timer_checker.sv
module scl_timer_checker
  import scl_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              slave_mode,
  input logic              scl_out,
  input logic              sda_strobe,
  input logic              hold_overrun,
  input logic              fall_evt,
  input logic              hold_pend,
  input phase_e            phase_q,
  input phase_e            phase_d,
  input logic [DATA_W-1:0] cfg_low,
  input logic [DATA_W-1:0] cfg_high,
  input logic [DATA_W-1:0] cfg_hold
);

  localparam int unsigned LEN_W = DATA_W + 4;

  logic [LEN_W-1:0] len_q, exp_q;

  // Measure each phase independently and record its expected length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      exp_q <= '0;
    end else if (phase_d != phase_q) begin
      len_q <= '0;
      if (phase_d == PH_LOW) begin
        exp_q <= LEN_W'(cfg_low) * LEN_W'(4) + LEN_W'(1);
      end else if (phase_d == PH_HIGH) begin
        exp_q <= LEN_W'(cfg_high) * LEN_W'(4) + LEN_W'(3);
      end else begin
        exp_q <= '0;
      end
    end else begin
      len_q <= len_q + 1'b1;
    end
  end

  a_r2_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && phase_d != PH_LOW && !slave_mode) |-> (len_q + 1'b1 == exp_q));

  a_r3_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && phase_d != PH_HIGH && !slave_mode) |-> (len_q + 1'b1 == exp_q));

  a_r4_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && fall_evt && cfg_hold == '0) |-> sda_strobe);

  a_r6_overrun_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    hold_overrun |-> (fall_evt && hold_pend));

  a_r6_overrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    hold_overrun |=> !hold_overrun);

  a_r8_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !run) |=> (phase_q == PH_IDLE));

  a_r10_slave_released: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && $past(slave_mode)) |-> scl_out);

endmodule

bind i2c_scl_timer scl_timer_checker #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_ni),
  .run         (run),
  .slave_mode  (slave_mode),
  .scl_out     (scl_out),
  .sda_strobe  (sda_strobe),
  .hold_overrun(hold_overrun),
  .fall_evt    (fall_sel),
  .hold_pend   (hold_pend),
  .phase_q     (phase_q),
  .phase_d     (phase_d),
  .cfg_low     (cfg_low),
  .cfg_high    (cfg_high),
  .cfg_hold    (cfg_hold)
);

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       run = 1'b0;
  logic       slave_mode = 1'b0;
  logic       scl_in = 1'b1;
  logic       scl_out, sda_strobe, hold_overrun;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_scl_timer i_i2c_scl_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .run(run), .slave_mode(slave_mode),
    .scl_in(scl_in), .scl_out(scl_out), .sda_strobe(sda_strobe),
    .hold_overrun(hold_overrun)
  );

  // ---------------- monitor (samples at negedge) ----------------
  int  cyc = 0;
  int  fall_n, ovr_n, stb_n, scl_low_n;
  int  fall_cyc, rise_cyc;
  bit  have_fall, have_rise;
  logic ref_prev = 1'b1;
  logic ref_now;
  int  low_q[$];
  int  high_q[$];
  int  stb_q[$];

  always @(negedge clk) begin
    cyc++;
    ref_now = slave_mode ? scl_in : scl_out;
    if (ref_prev && !ref_now) begin
      if (have_rise) high_q.push_back(cyc - rise_cyc);
      fall_cyc  = cyc;
      have_fall = 1'b1;
      fall_n++;
    end
    if (!ref_prev && ref_now) begin
      if (have_fall) low_q.push_back(cyc - fall_cyc);
      rise_cyc  = cyc;
      have_rise = 1'b1;
    end
    if (sda_strobe) begin
      stb_n++;
      if (have_fall) stb_q.push_back(cyc - fall_cyc);
    end
    if (hold_overrun) ovr_n++;
    if (!scl_out) scl_low_n++;
    ref_prev = ref_now;
  end

  task automatic mon_clear();
    low_q.delete(); high_q.delete(); stb_q.delete();
    fall_n = 0; ovr_n = 0; stb_n = 0; scl_low_n = 0;
    have_fall = 1'b0; have_rise = 1'b0;
    ref_prev = slave_mode ? scl_in : scl_out;
  endtask

  // ---------------- helpers ----------------
  task automatic step();
    @(posedge clk);
    #4;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic reg_check(input int addr, input int exp, input string tag);
    rd_addr = 2'(addr);
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic wait_falls(input int n);
    int g = 0;
    while (fall_n < n && g < 20000) begin step(); g++; end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    reg_check(0, 8'h3F, "R1 low reg reset");
    reg_check(1, 8'h3F, "R1 high reg reset");
    reg_check(2, 8'h01, "R1 hold reg reset");
    chk("R1 scl idle high", int'(scl_out), 1);
    chk("R1 strobe idle", int'(sda_strobe), 0);
    chk("R1 overrun idle", int'(hold_overrun), 0);
  endtask

  task automatic t_regs();
    reg_write(0, 8'h12);
    reg_write(1, 8'hA5);
    reg_write(2, 8'h00);
    reg_write(3, 8'h77);
    reg_check(0, 8'h12, "R9 low readback");
    reg_check(1, 8'hA5, "R9 high readback");
    reg_check(2, 8'h00, "R9 hold readback");
    reg_check(3, 0, "R9 addr3 reads zero");
  endtask

  task automatic t_master(input int l, input int h, input int d, input int nper);
    int g = 0;
    reg_write(0, l); reg_write(1, h); reg_write(2, d);
    mon_clear();
    run = 1'b1;
    while (high_q.size() < nper && g < 20000) begin step(); g++; end
    run = 1'b0;
    steps((4*l+1) + (4*h+3) + d + 10);
    chk("R2 low count", (low_q.size() >= nper) ? 1 : 0, 1);
    for (int i = 0; i < nper && i < low_q.size(); i++) chk("R2 low width", low_q[i], 4*l+1);
    for (int i = 0; i < nper && i < high_q.size(); i++) chk("R3 high width", high_q[i], 4*h+3);
    chk("R4 one strobe per edge", stb_n, fall_n);
    for (int i = 0; i < stb_q.size(); i++) chk("R4 edge to strobe", stb_q[i], d);
  endtask

  task automatic t_midwrite();
    int g = 0;
    reg_write(0, 5); reg_write(1, 5); reg_write(2, 1);
    mon_clear();
    run = 1'b1;
    wait_falls(1);
    steps(3);
    reg_write(0, 10);
    reg_write(1, 2);
    while (low_q.size() < 2 && g < 20000) begin step(); g++; end
    run = 1'b0;
    steps(60);
    chk("R7 running low keeps old length", low_q.size() > 0 ? low_q[0] : -1, 21);
    chk("R7 next high uses new value", high_q.size() > 0 ? high_q[0] : -1, 11);
    chk("R7 next low uses new value", low_q.size() > 1 ? low_q[1] : -1, 41);
  endtask

  task automatic t_stop();
    reg_write(0, 1); reg_write(1, 2); reg_write(2, 1);
    // stop while low
    mon_clear();
    run = 1'b1;
    wait_falls(2);
    step();
    run = 1'b0;
    steps(60);
    chk("R8 no low after stop", fall_n, 2);
    chk("R8 low phase completes", low_q.size() > 1 ? low_q[1] : -1, 5);
    chk("R8 scl released", int'(scl_out), 1);
    // stop while high
    mon_clear();
    run = 1'b1;
    wait_falls(1);
    while (!scl_out) step();
    run = 1'b0;
    steps(40);
    chk("R8 stop in high phase", fall_n, 1);
    chk("R8 scl stays high", int'(scl_out), 1);
  endtask

  task automatic t_master_overrun();
    reg_write(0, 0); reg_write(1, 0); reg_write(2, 6);
    mon_clear();
    run = 1'b1;
    wait_falls(5);
    run = 1'b0;
    steps(30);
    chk("R6 master edges", fall_n, 5);
    chk("R6 master overrun count", ovr_n, 4);
    chk("R6 master surviving strobes", stb_n, 1);
    chk("R6 master strobe from last edge", stb_q.size() > 0 ? stb_q[0] : -1, 6);
  endtask

  task automatic drive_scl(input int lo, input int hi, input int n);
    for (int i = 0; i < n; i++) begin
      scl_in = 1'b0; steps(lo);
      scl_in = 1'b1; steps(hi);
    end
  endtask

  task automatic t_slave(input int d, input int lo, input int hi, input int n);
    reg_write(2, d);
    slave_mode = 1'b1;
    run = 1'b1;
    steps(6);
    mon_clear();
    drive_scl(lo, hi, n);
    steps(30);
    chk("R5 slave strobe count", stb_n, n);
    for (int i = 0; i < stb_q.size(); i++) chk("R5 slave edge to strobe", stb_q[i], d + 4);
    chk("R10 scl held high in slave", scl_low_n, 0);
    run = 1'b0;
    slave_mode = 1'b0;
    steps(6);
  endtask

  task automatic t_slave_overrun();
    reg_write(2, 20);
    slave_mode = 1'b1;
    steps(6);
    mon_clear();
    drive_scl(5, 5, 4);
    steps(40);
    chk("R6 slave overrun count", ovr_n, 3);
    chk("R6 slave surviving strobes", stb_n, 1);
    chk("R6 slave strobe from last edge", stb_q.size() > 0 ? stb_q[0] : -1, 24);
    slave_mode = 1'b0;
    steps(6);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  // ---------------- main ----------------
  initial begin
    steps(5);
    rst_n = 1'b1;
    steps(4);
    t_reset();
    t_regs();
    t_master(0, 0, 0, 4);
    t_master(2, 1, 0, 4);
    t_master(5, 3, 7, 4);
    for (int k = 0; k < 3; k++) begin
      int l = $urandom_range(1, 30);
      int h = $urandom_range(0, 30);
      int per = (4*l+1) + (4*h+3);
      int d = $urandom_range(0, (per - 1 > 255) ? 255 : per - 1);
      t_master(l, h, d, 3);
    end
    t_midwrite();
    t_stop();
    t_master_overrun();
    t_slave(3, 12, 12, 4);
    t_slave(0, 6, 6, 3);
    t_slave_overrun();
    finish_run();
  end

endmodule